// File: doc/BRIEF.md
# Instruction Dispatch Router

The dispatch router accepts a group of up to `SLOTS` renamed instructions each cycle and decides, slot by slot in ascending order, where each one goes: the schedulable instruction queue, the load or store side of the memory ordering queue, the holding area for instructions that must wait until they are oldest, or straight past the queue as an already-finished nop. Every slot carries its own category flags. The block also receives the queue's full indication and its current count of free entries.

The block emits one-hot-per-slot insert strobes for every target and status-set strobes (issued, executed, can-commit). It also emits a block request with the index of the first slot that was not dispatched, so that a stall controller can hold the rest of the group. Six event counters wrap around. All outputs are registered, so results for a group appear one clock after the group is presented. The queue storage itself lives outside this block.

Top module: `dispatch_router`

## Requirements
- R1: While `rst` is high at a clock edge, every strobe output, `block_req` and `resume_idx` become 0 after that edge, and all six counters become 0.
- R2: Only slots below the effective group size take part in dispatch. The effective size is `grp_size` clamped to `SLOTS`, or 0 when `grp_valid` is low. Slots at or above it raise no strobe and change no counter.
- R3: A slot with `flg_squash` set raises no strobe and consumes no queue entry, and `cnt_squash` rises by one for it. This check comes before the full check, so a squashed slot is counted even while the queue is full.
- R4: The first non-squashed slot that meets a full queue halts the group. The queue is full when `iq_full` is high, or when `iq_free` minus the number of instruction-queue inserts already made for earlier slots of this group is zero. The halting slot and every later slot raise no strobe and change no counter. `block_req` is 1, `resume_idx` equals the halting slot's index, and `cnt_full` rises by one.
- R5: A slot with `flg_load` set (and not squashed or halted) raises `iq_ins` and `lsq_ld_ins` and increments `cnt_load`. The load flag takes priority over all later category flags.
- R6: A slot with `flg_store` set and `flg_load` clear raises `iq_ins` and `lsq_st_ins` and increments `cnt_store`. The store flag takes priority over the non-speculative and nop flags.
- R7: A slot whose first set category flag is `flg_nonspec` raises `ns_ins` and `set_cancommit`, never `iq_ins`, and increments `cnt_nonspec`. The non-speculative flag takes priority over the nop flag.
- R8: A slot whose first set category flag is `flg_nop` raises `tail_adv`, `set_issued`, `set_executed` and `set_cancommit`, never `iq_ins`, and does not reduce the free-entry budget seen by later slots.
- R9: A slot with no category flag set raises `iq_ins` only. `cnt_disp` counts every `iq_ins` strobe, which covers normal, load and store slots.
- R10: When no slot halts, `block_req` is 0 and `resume_idx` equals the effective group size. Every output reflects the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A group is presented this cycle |
| grp_size | input | SZ_W | Number of instructions in the group |
| flg_squash | input | SLOTS | Per-slot squashed flag |
| flg_load | input | SLOTS | Per-slot load flag |
| flg_store | input | SLOTS | Per-slot store flag |
| flg_nonspec | input | SLOTS | Per-slot non-speculative flag |
| flg_nop | input | SLOTS | Per-slot nop flag |
| iq_full | input | 1 | Instruction queue reports full |
| iq_free | input | FREE_W | Free instruction-queue entries |
| iq_ins | output | SLOTS | Insert into instruction queue |
| lsq_ld_ins | output | SLOTS | Reserve load entry in memory ordering queue |
| lsq_st_ins | output | SLOTS | Reserve store entry in memory ordering queue |
| ns_ins | output | SLOTS | Insert into non-speculative holding area |
| tail_adv | output | SLOTS | Advance queue tail for a finished nop |
| set_issued | output | SLOTS | Set issued status bit |
| set_executed | output | SLOTS | Set executed status bit |
| set_cancommit | output | SLOTS | Set can-commit status bit |
| block_req | output | 1 | Group halted on a full queue; stall upstream |
| resume_idx | output | SZ_W | First slot not dispatched |
| cnt_squash | output | CNT_W | Squashed slots skipped |
| cnt_full | output | CNT_W | Groups halted on a full queue |
| cnt_load | output | CNT_W | Loads dispatched |
| cnt_store | output | CNT_W | Stores dispatched |
| cnt_nonspec | output | CNT_W | Non-speculative instructions dispatched |
| cnt_disp | output | CNT_W | Instruction-queue inserts |

## Verification
Every strobe, the block request, the resume index and all counters are due exactly one rising edge after the group is driven. The bench drives each group on a falling edge and compares all outputs on the next falling edge, after the single register stage has loaded. Expected counter values accumulate in the bench from the same per-group reference computation, so any counter off by one shows up on the cycle it happens rather than at the end.

// File: rtl/dr_pkg.sv
package dr_pkg;

  typedef enum logic [2:0] {
    CAT_NORMAL,
    CAT_SQUASH,
    CAT_LOAD,
    CAT_STORE,
    CAT_NONSPEC,
    CAT_NOP
  } slot_cat_e;

  localparam int CI_SQUASH  = 0;
  localparam int CI_FULL    = 1;
  localparam int CI_LOAD    = 2;
  localparam int CI_STORE   = 3;
  localparam int CI_NONSPEC = 4;
  localparam int CI_DISP    = 5;
  localparam int NUM_CNT    = 6;

endpackage

// File: rtl/slot_classify.sv
module slot_classify
  import dr_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0] flg_squash,
  input  logic [SLOTS-1:0] flg_load,
  input  logic [SLOTS-1:0] flg_store,
  input  logic [SLOTS-1:0] flg_nonspec,
  input  logic [SLOTS-1:0] flg_nop,
  output slot_cat_e        cat [SLOTS]
);

  // Fixed priority per slot; the full-queue test sits between squash and the
  // rest and is applied by the scan stage.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_comb begin
      if (flg_squash[s])       cat[s] = CAT_SQUASH;
      else if (flg_load[s])    cat[s] = CAT_LOAD;
      else if (flg_store[s])   cat[s] = CAT_STORE;
      else if (flg_nonspec[s]) cat[s] = CAT_NONSPEC;
      else if (flg_nop[s])     cat[s] = CAT_NOP;
      else                     cat[s] = CAT_NORMAL;
    end
  end

endmodule

// File: rtl/dispatch_scan.sv
module dispatch_scan
  import dr_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int SZ_W   = 3,
  parameter int FREE_W = 5
) (
  input  logic                              grp_valid,
  input  logic [SZ_W-1:0]                   grp_size,
  input  slot_cat_e                         cat [SLOTS],
  input  logic                              iq_full,
  input  logic [FREE_W-1:0]                 iq_free,
  output logic [SLOTS-1:0]                  iq_ins,
  output logic [SLOTS-1:0]                  ld_ins,
  output logic [SLOTS-1:0]                  st_ins,
  output logic [SLOTS-1:0]                  ns_ins,
  output logic [SLOTS-1:0]                  nop_ins,
  output logic                              halt,
  output logic [SZ_W-1:0]                   stop_idx,
  output logic [NUM_CNT-1:0][SZ_W-1:0]      inc
);

  logic [SZ_W-1:0]   eff_size;
  logic [FREE_W-1:0] used;

  always_comb begin
    if (!grp_valid)                 eff_size = '0;
    else if (grp_size > SZ_W'(SLOTS)) eff_size = SZ_W'(SLOTS);
    else                            eff_size = grp_size;
  end

  always_comb begin
    iq_ins   = '0;
    ld_ins   = '0;
    st_ins   = '0;
    ns_ins   = '0;
    nop_ins  = '0;
    halt     = 1'b0;
    stop_idx = eff_size;
    inc      = '0;
    used     = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (SZ_W'(s) < eff_size && !halt) begin
        if (cat[s] == CAT_SQUASH) begin
          inc[CI_SQUASH] = inc[CI_SQUASH] + SZ_W'(1);
        end else if (iq_full || used >= iq_free) begin
          halt          = 1'b1;
          stop_idx      = SZ_W'(s);
          inc[CI_FULL]  = SZ_W'(1);
        end else begin
          unique case (cat[s])
            CAT_LOAD: begin
              iq_ins[s] = 1'b1;
              ld_ins[s] = 1'b1;
              inc[CI_LOAD] = inc[CI_LOAD] + SZ_W'(1);
            end
            CAT_STORE: begin
              iq_ins[s] = 1'b1;
              st_ins[s] = 1'b1;
              inc[CI_STORE] = inc[CI_STORE] + SZ_W'(1);
            end
            CAT_NONSPEC: begin
              ns_ins[s] = 1'b1;
              inc[CI_NONSPEC] = inc[CI_NONSPEC] + SZ_W'(1);
            end
            CAT_NOP:    nop_ins[s] = 1'b1;
            default:    iq_ins[s]  = 1'b1;
          endcase
          if (iq_ins[s]) begin
            used         = used + FREE_W'(1);
            inc[CI_DISP] = inc[CI_DISP] + SZ_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/event_counters.sv
module event_counters #(
  parameter int NUM   = 6,
  parameter int CNT_W = 16,
  parameter int INC_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM-1:0][INC_W-1:0]   inc,
  output logic [NUM-1:0][CNT_W-1:0]   cnt
);

  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt[i] <= '0;
      else     cnt[i] <= cnt[i] + CNT_W'(inc[i]);
    end
  end

endmodule

// File: rtl/dispatch_router.sv
module dispatch_router
  import dr_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int IQ_DEPTH = 16,
  parameter int CNT_W    = 16,
  localparam int SZ_W    = $clog2(SLOTS + 1),
  localparam int FREE_W  = $clog2(IQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_valid,
  input  logic [SZ_W-1:0]   grp_size,
  input  logic [SLOTS-1:0]  flg_squash,
  input  logic [SLOTS-1:0]  flg_load,
  input  logic [SLOTS-1:0]  flg_store,
  input  logic [SLOTS-1:0]  flg_nonspec,
  input  logic [SLOTS-1:0]  flg_nop,
  input  logic              iq_full,
  input  logic [FREE_W-1:0] iq_free,
  output logic [SLOTS-1:0]  iq_ins,
  output logic [SLOTS-1:0]  lsq_ld_ins,
  output logic [SLOTS-1:0]  lsq_st_ins,
  output logic [SLOTS-1:0]  ns_ins,
  output logic [SLOTS-1:0]  tail_adv,
  output logic [SLOTS-1:0]  set_issued,
  output logic [SLOTS-1:0]  set_executed,
  output logic [SLOTS-1:0]  set_cancommit,
  output logic              block_req,
  output logic [SZ_W-1:0]   resume_idx,
  output logic [CNT_W-1:0]  cnt_squash,
  output logic [CNT_W-1:0]  cnt_full,
  output logic [CNT_W-1:0]  cnt_load,
  output logic [CNT_W-1:0]  cnt_store,
  output logic [CNT_W-1:0]  cnt_nonspec,
  output logic [CNT_W-1:0]  cnt_disp
);

  slot_cat_e                       cat [SLOTS];
  logic [SLOTS-1:0]                c_iq, c_ld, c_st, c_ns, c_nop;
  logic                            c_halt;
  logic [SZ_W-1:0]                 c_idx;
  logic [NUM_CNT-1:0][SZ_W-1:0]    c_inc;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt;

  slot_classify #(.SLOTS(SLOTS)) u_classify (
    .flg_squash (flg_squash),
    .flg_load   (flg_load),
    .flg_store  (flg_store),
    .flg_nonspec(flg_nonspec),
    .flg_nop    (flg_nop),
    .cat        (cat)
  );

  dispatch_scan #(.SLOTS(SLOTS), .SZ_W(SZ_W), .FREE_W(FREE_W)) u_scan (
    .grp_valid(grp_valid),
    .grp_size (grp_size),
    .cat      (cat),
    .iq_full  (iq_full),
    .iq_free  (iq_free),
    .iq_ins   (c_iq),
    .ld_ins   (c_ld),
    .st_ins   (c_st),
    .ns_ins   (c_ns),
    .nop_ins  (c_nop),
    .halt     (c_halt),
    .stop_idx (c_idx),
    .inc      (c_inc)
  );

  event_counters #(.NUM(NUM_CNT), .CNT_W(CNT_W), .INC_W(SZ_W)) u_counters (
    .clk(clk),
    .rst(rst),
    .inc(c_inc),
    .cnt(cnt)
  );

  assign cnt_squash  = cnt[CI_SQUASH];
  assign cnt_full    = cnt[CI_FULL];
  assign cnt_load    = cnt[CI_LOAD];
  assign cnt_store   = cnt[CI_STORE];
  assign cnt_nonspec = cnt[CI_NONSPEC];
  assign cnt_disp    = cnt[CI_DISP];

  always_ff @(posedge clk) begin
    if (rst) begin
      iq_ins        <= '0;
      lsq_ld_ins    <= '0;
      lsq_st_ins    <= '0;
      ns_ins        <= '0;
      tail_adv      <= '0;
      set_issued    <= '0;
      set_executed  <= '0;
      set_cancommit <= '0;
      block_req     <= 1'b0;
      resume_idx    <= '0;
    end else begin
      iq_ins        <= c_iq;
      lsq_ld_ins    <= c_ld;
      lsq_st_ins    <= c_st;
      ns_ins        <= c_ns;
      tail_adv      <= c_nop;
      set_issued    <= c_nop;
      set_executed  <= c_nop;
      set_cancommit <= c_nop | c_ns;
      block_req     <= c_halt;
      resume_idx    <= c_idx;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (block_req == 1'b0 && iq_ins == '0 && cnt_disp == '0));

  // R4
  full_blocks_insert_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(iq_full) && !$past(rst)) |-> (iq_ins == '0));

  // R4
  free_budget_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(iq_ins) <= int'($past(iq_free))));

  // R4
  full_event_count_chk: assert property (@(posedge clk) disable iff (rst)
    block_req |-> (cnt_full == CNT_W'($past(cnt_full) + 1'b1)));

  // R7
  nonspec_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_ins & iq_ins) == '0);

  // R8
  nop_marks_chk: assert property (@(posedge clk) disable iff (rst)
    ((tail_adv & ~(set_issued & set_executed & set_cancommit)) == '0)
    && ((tail_adv & iq_ins) == '0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(grp_valid) |-> (iq_ins == '0 && ns_ins == '0 && tail_adv == '0
                          && block_req == 1'b0));

endmodule

// File: tb/dispatch_router_bench.sv
`timescale 1ns/1ps
module dispatch_router_bench;

  localparam int SLOTS    = 4;
  localparam int IQ_DEPTH = 16;
  localparam int CNT_W    = 16;
  localparam int SZ_W     = $clog2(SLOTS + 1);
  localparam int FREE_W   = $clog2(IQ_DEPTH + 1);

  logic clk = 1'b0;
  logic rst;
  logic grp_valid;
  logic [SZ_W-1:0] grp_size;
  logic [SLOTS-1:0] flg_squash, flg_load, flg_store, flg_nonspec, flg_nop;
  logic iq_full;
  logic [FREE_W-1:0] iq_free;
  logic [SLOTS-1:0] iq_ins, lsq_ld_ins, lsq_st_ins, ns_ins, tail_adv;
  logic [SLOTS-1:0] set_issued, set_executed, set_cancommit;
  logic block_req;
  logic [SZ_W-1:0] resume_idx;
  logic [CNT_W-1:0] cnt_squash, cnt_full, cnt_load, cnt_store, cnt_nonspec, cnt_disp;

  always #2.5 clk = ~clk;

  dispatch_router #(.SLOTS(SLOTS), .IQ_DEPTH(IQ_DEPTH), .CNT_W(CNT_W)) u_dispatch_router (
    .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_size(grp_size),
    .flg_squash(flg_squash), .flg_load(flg_load), .flg_store(flg_store),
    .flg_nonspec(flg_nonspec), .flg_nop(flg_nop), .iq_full(iq_full),
    .iq_free(iq_free), .iq_ins(iq_ins), .lsq_ld_ins(lsq_ld_ins),
    .lsq_st_ins(lsq_st_ins), .ns_ins(ns_ins), .tail_adv(tail_adv),
    .set_issued(set_issued), .set_executed(set_executed),
    .set_cancommit(set_cancommit), .block_req(block_req),
    .resume_idx(resume_idx), .cnt_squash(cnt_squash), .cnt_full(cnt_full),
    .cnt_load(cnt_load), .cnt_store(cnt_store), .cnt_nonspec(cnt_nonspec),
    .cnt_disp(cnt_disp)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [SLOTS-1:0] e_iq, e_ld, e_st, e_ns, e_nop;
  logic e_block;
  int   e_idx;
  int   m_sq, m_full, m_ld, m_st, m_ns, m_disp;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference from the requirements: computes this group's strobes and
  // accumulates the expected counters.
  task automatic model();
    int eff;
    int used;
    eff = !grp_valid ? 0 : (int'(grp_size) > SLOTS ? SLOTS : int'(grp_size));
    e_iq = '0; e_ld = '0; e_st = '0; e_ns = '0; e_nop = '0;
    e_block = 1'b0; e_idx = eff; used = 0;
    for (int s = 0; s < eff; s++) begin
      if (flg_squash[s]) begin
        m_sq++;
      end else if (iq_full || used >= int'(iq_free)) begin
        e_block = 1'b1; e_idx = s; m_full++;
        break;
      end else if (flg_load[s]) begin
        e_iq[s] = 1'b1; e_ld[s] = 1'b1; m_ld++; used++; m_disp++;
      end else if (flg_store[s]) begin
        e_iq[s] = 1'b1; e_st[s] = 1'b1; m_st++; used++; m_disp++;
      end else if (flg_nonspec[s]) begin
        e_ns[s] = 1'b1; m_ns++;
      end else if (flg_nop[s]) begin
        e_nop[s] = 1'b1;
      end else begin
        e_iq[s] = 1'b1; used++; m_disp++;
      end
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "iq_ins", iq_ins, e_iq);
    chk(tag, "lsq_ld_ins", lsq_ld_ins, e_ld);
    chk(tag, "lsq_st_ins", lsq_st_ins, e_st);
    chk(tag, "ns_ins", ns_ins, e_ns);
    chk(tag, "tail_adv", tail_adv, e_nop);
    chk(tag, "set_issued", set_issued, e_nop);
    chk(tag, "set_executed", set_executed, e_nop);
    chk(tag, "set_cancommit", set_cancommit, e_nop | e_ns);
    chk(tag, "block_req", block_req, e_block);
    chk(tag, "resume_idx", resume_idx, e_idx);
    chk(tag, "cnt_squash", cnt_squash, CNT_W'(m_sq));
    chk(tag, "cnt_full", cnt_full, CNT_W'(m_full));
    chk(tag, "cnt_load", cnt_load, CNT_W'(m_ld));
    chk(tag, "cnt_store", cnt_store, CNT_W'(m_st));
    chk(tag, "cnt_nonspec", cnt_nonspec, CNT_W'(m_ns));
    chk(tag, "cnt_disp", cnt_disp, CNT_W'(m_disp));
  endtask

  // Called on a falling edge: drive, let one rising edge register, then
  // compare on the next falling edge.
  task automatic apply(string tag, logic v, int sz, logic [SLOTS-1:0] sq,
                       logic [SLOTS-1:0] ld, logic [SLOTS-1:0] st,
                       logic [SLOTS-1:0] ns, logic [SLOTS-1:0] np,
                       logic full, int free);
    grp_valid = v; grp_size = SZ_W'(sz);
    flg_squash = sq; flg_load = ld; flg_store = st;
    flg_nonspec = ns; flg_nop = np;
    iq_full = full; iq_free = FREE_W'(free);
    model();
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    rst = 1'b1;
    grp_valid = 1'b1; grp_size = SZ_W'(SLOTS);
    flg_squash = '0; flg_load = '1; flg_store = '0; flg_nonspec = '0; flg_nop = '0;
    iq_full = 1'b0; iq_free = FREE_W'(IQ_DEPTH);
    m_sq = 0; m_full = 0; m_ld = 0; m_st = 0; m_ns = 0; m_disp = 0;
    repeat (3) @(negedge clk);
    // R1: reset state with a live group on the inputs
    e_iq = '0; e_ld = '0; e_st = '0; e_ns = '0; e_nop = '0;
    e_block = 1'b0; e_idx = 0;
    check_all("R1");
    rst = 1'b0;

    // R9: all normal, plenty of room
    apply("R9", 1, 4, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 16);
    // R3: squashed slot is counted even with the queue full, then halt
    apply("R3", 1, 4, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 16);
    // R4: free count runs out after two inserts
    apply("R4", 1, 4, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 2);
    // R4: zero free halts slot 0
    apply("R4", 1, 3, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0);
    // R5 R6: load then store consume budget; nonspec at slot 2 halted
    apply("R5", 1, 4, 4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 0, 2);
    // R6 R7 R8: mixed group with ample room
    apply("R7", 1, 4, 4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 0, 8);
    // R8: nops do not use the budget
    apply("R8", 1, 4, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0011, 0, 1);
    // R5: load beats store; R7: nonspec beats nop
    apply("R5", 1, 2, 4'b0000, 4'b0001, 4'b0001, 4'b0010, 4'b0010, 0, 8);
    apply("R6", 1, 2, 4'b0000, 4'b0000, 4'b0001, 4'b0001, 4'b0011, 0, 8);
    // R2: partial group and oversized group
    apply("R2", 1, 2, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 16);
    apply("R2", 1, 7, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 16);
    // R2: no group
    apply("R2", 0, 4, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 0, 16);
    // R10: zero-size valid group resumes at 0 with no block
    apply("R10", 1, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 0);

    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 400; n++) begin
      apply("R10", ($urandom_range(0, 7) != 0), int'($urandom_range(0, SLOTS + 1)),
            SLOTS'($urandom) & SLOTS'($urandom), SLOTS'($urandom) & SLOTS'($urandom),
            SLOTS'($urandom) & SLOTS'($urandom), SLOTS'($urandom) & SLOTS'($urandom),
            SLOTS'($urandom), ($urandom_range(0, 7) == 0),
            int'($urandom_range(0, IQ_DEPTH)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule